// File: doc/BRIEF.md
# Paged Register File Address Unit

This block owns a byte-wide register file of 4096 entries and an 8-bit register pointer. Short operand addresses are expanded to 12-bit physical addresses using the pointer. There are three address forms. A 4-bit working-register form picks one of sixteen registers in the active group of the active page. An 8-bit in-page form picks any byte of the active page. A full 12-bit form ignores the pointer.

Both forms of the pointer are used, but with its nibbles in swapped roles: the low nibble names the page and the high nibble names the working group. A set-pointer strobe loads the pointer from the low byte of the write data.

Accesses are either single bytes or 16-bit register pairs. A pair keeps its high byte in the even register and its low byte in the odd register that follows it. Reads are combinational. Writes take effect on the rising clock edge.

Top module: `paged_regfile`

## Requirements
- R1: After reset the pointer holds 0x00, so working register n maps to physical address 0x00n.
- R2: When setPtr is high at a rising edge, the pointer takes wrData[7:0], and later working and in-page accesses use the new value.
- R3: With addrMode = 2'b00 the physical address is {ptr[3:0], ptr[7:4], opAddr[3:0]}, and opAddr[11:4] has no effect (pointer 0x73 with register 6 reaches 0x376).
- R4: With addrMode = 2'b01 the physical address is {ptr[3:0], opAddr[7:0]}, and opAddr[11:8] has no effect.
- R5: With addrMode[1] = 1 the physical address is opAddr[11:0], whatever the pointer holds.
- R6: A byte read (wordSel = 0) returns {8'h00, entry} combinationally from the addressed entry.
- R7: A pair read (wordSel = 1) returns the even entry on rdData[15:8] and the odd entry on rdData[7:0]. Bit 0 of the physical address is cleared first.
- R8: A pair write stores wrData[15:8] in the even entry and wrData[7:0] in the odd entry on one edge, with bit 0 of the physical address cleared first.
- R9: A byte write stores wrData[7:0] at the addressed entry only, leaving its pair partner unchanged.
- R10: When setPtr and wrEn are both high on an edge, only the pointer load takes place and the register file is unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rstN | input | 1 | Active-low asynchronous reset of the pointer |
| setPtr | input | 1 | Load the pointer from wrData[7:0] |
| addrMode | input | 2 | 00 working register, 01 in-page, 1x full address |
| opAddr | input | 12 | Operand address; bits used depend on addrMode |
| wordSel | input | 1 | 0 byte access, 1 register-pair access |
| wrEn | input | 1 | Write the register file at the rising edge |
| wrData | input | 16 | Write data; also the pointer source |
| rdData | output | 16 | Combinational read data |

## Verification
A wrong pointer value is not visible on its own. It shows up in the first working or in-page read after the pointer load, as data from the wrong group or page. So each pointer value is followed at once by reads that cover all sixteen of its working registers. A wrong pair mapping shows at once in a combinational pair read, as swapped bytes or data from a neighbouring pair. A stray write shows only when the damaged entry is read again. The bench therefore reads back the partner and neighbour entries right after each write.

// File: rtl/regfile_pkg.sv
package regfile_pkg;
  localparam int PAGE_W  = 4;
  localparam int GROUP_W = 4;
  localparam int REG_W   = 4;
  localparam int BYTE_W  = 8;
  localparam int PTR_W   = PAGE_W + GROUP_W;
  localparam int PHYS_W  = PAGE_W + GROUP_W + REG_W;
  localparam int OFFS_W  = GROUP_W + REG_W;
  localparam int DEPTH   = 1 << PHYS_W;
  localparam int WORD_W  = 2 * BYTE_W;

  typedef logic [PHYS_W-1:0] physAddr_t;

  typedef enum logic [1:0] {
    MODE_WORK = 2'b00,
    MODE_PAGE = 2'b01,
    MODE_FULL = 2'b10,
    MODE_FULL_ALT = 2'b11
  } addrMode_e;

  typedef struct packed {
    logic      wrFirst;
    logic      wrSecond;
    logic      pair;
    physAddr_t firstAddr;
    physAddr_t secondAddr;
  } rfStrobes_t;
endpackage

// File: rtl/rf_addr_ctrl.sv
module rf_addr_ctrl
  import regfile_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              setPtr,
  input  logic [PTR_W-1:0]  ptrIn,
  input  logic [1:0]        addrMode,
  input  logic [PHYS_W-1:0] opAddr,
  input  logic              wordSel,
  input  logic              wrEn,
  output rfStrobes_t        strobes,
  output logic [PTR_W-1:0]  ptrQ
);
  logic [PAGE_W-1:0]  pageSel;
  logic [GROUP_W-1:0] groupSel;
  physAddr_t          physAddr;
  physAddr_t          evenAddr;
  logic               doWrite;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ptrQ <= '0;
    end else if (setPtr) begin
      ptrQ <= ptrIn;
    end
  end

  assign pageSel  = ptrQ[PAGE_W-1:0];
  assign groupSel = ptrQ[PTR_W-1:PAGE_W];

  always_comb begin
    unique case (addrMode_e'(addrMode))
      MODE_WORK: physAddr = {pageSel, groupSel, opAddr[REG_W-1:0]};
      MODE_PAGE: physAddr = {pageSel, opAddr[OFFS_W-1:0]};
      default:   physAddr = opAddr;
    endcase
  end

  assign evenAddr = {physAddr[PHYS_W-1:1], 1'b0};
  assign doWrite  = wrEn && !setPtr;

  always_comb begin
    strobes.pair    = wordSel;
    strobes.wrFirst = doWrite;
    if (wordSel) begin
      strobes.firstAddr  = evenAddr;
      strobes.secondAddr = {physAddr[PHYS_W-1:1], 1'b1};
      strobes.wrSecond   = doWrite;
    end else begin
      strobes.firstAddr  = physAddr;
      strobes.secondAddr = physAddr;
      strobes.wrSecond   = 1'b0;
    end
  end
endmodule

// File: rtl/rf_datapath.sv
module rf_datapath
  import regfile_pkg::*;
(
  input  logic              clk,
  input  rfStrobes_t        strobes,
  input  logic [WORD_W-1:0] wrData,
  output logic [WORD_W-1:0] rdData
);
  logic [BYTE_W-1:0] mem [DEPTH];
  logic [BYTE_W-1:0] firstData;

  assign firstData = strobes.pair ? wrData[WORD_W-1:BYTE_W] : wrData[BYTE_W-1:0];

  always_ff @(posedge clk) begin
    if (strobes.wrFirst) begin
      mem[strobes.firstAddr] <= firstData;
    end
    if (strobes.wrSecond) begin
      mem[strobes.secondAddr] <= wrData[BYTE_W-1:0];
    end
  end

  always_comb begin
    if (strobes.pair) begin
      rdData = {mem[strobes.firstAddr], mem[strobes.secondAddr]};
    end else begin
      rdData = {{BYTE_W{1'b0}}, mem[strobes.firstAddr]};
    end
  end
endmodule

// File: rtl/paged_regfile.sv
module paged_regfile
  import regfile_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              setPtr,
  input  logic [1:0]        addrMode,
  input  logic [PHYS_W-1:0] opAddr,
  input  logic              wordSel,
  input  logic              wrEn,
  input  logic [WORD_W-1:0] wrData,
  output logic [WORD_W-1:0] rdData
);
  rfStrobes_t        strobes;
  logic [PTR_W-1:0]  ptrQ;

  rf_addr_ctrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .setPtr   (setPtr),
    .ptrIn    (wrData[PTR_W-1:0]),
    .addrMode (addrMode),
    .opAddr   (opAddr),
    .wordSel  (wordSel),
    .wrEn     (wrEn),
    .strobes  (strobes),
    .ptrQ     (ptrQ)
  );

  rf_datapath u_data (
    .clk     (clk),
    .strobes (strobes),
    .wrData  (wrData),
    .rdData  (rdData)
  );
endmodule

// File: rtl/paged_regfile_chk.sv
module paged_regfile_chk
  import regfile_pkg::*;
(
  input logic              clk,
  input logic              rstN,
  input logic              setPtr,
  input logic [1:0]        addrMode,
  input logic [PHYS_W-1:0] opAddr,
  input logic              wordSel,
  input logic              wrEn,
  input logic [WORD_W-1:0] wrData,
  input logic [WORD_W-1:0] rdData,
  input logic [PTR_W-1:0]  ptrQ
);
  logic pastValid;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) pastValid <= 1'b0;
    else       pastValid <= 1'b1;
  end

  // R2
  ptr_load_chk: assert property (@(posedge clk) disable iff (!rstN)
    (pastValid && setPtr) |=> (ptrQ == $past(wrData[PTR_W-1:0])));

  // R2
  ptr_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (pastValid && !setPtr) |=> $stable(ptrQ));

  // R6
  byte_upper_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    !wordSel |-> (rdData[WORD_W-1:BYTE_W] == '0));

  // R8
  pair_readback_chk: assert property (@(posedge clk) disable iff (!rstN)
    (pastValid && wrEn && !setPtr && wordSel) |=>
      (!($stable(opAddr) && $stable(addrMode) && wordSel) || rdData == $past(wrData)));

  // R9
  byte_readback_chk: assert property (@(posedge clk) disable iff (!rstN)
    (pastValid && wrEn && !setPtr && !wordSel) |=>
      (!($stable(opAddr) && $stable(addrMode) && !wordSel) ||
       rdData[BYTE_W-1:0] == $past(wrData[BYTE_W-1:0])));
endmodule

bind paged_regfile paged_regfile_chk u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .setPtr   (setPtr),
  .addrMode (addrMode),
  .opAddr   (opAddr),
  .wordSel  (wordSel),
  .wrEn     (wrEn),
  .wrData   (wrData),
  .rdData   (rdData),
  .ptrQ     (ptrQ)
);

// File: tb/paged_regfile_bench.sv
module paged_regfile_bench;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        setPtr = 1'b0;
  logic [1:0]  addrMode = 2'b10;
  logic [11:0] opAddr = '0;
  logic        wordSel = 1'b0;
  logic        wrEn = 1'b0;
  logic [15:0] wrData = '0;
  logic [15:0] rdData;

  int nChecks = 0;
  int nFails  = 0;
  bit done    = 1'b0;

  always #2 clk = ~clk;

  paged_regfile u_paged_regfile (
    .clk(clk), .rstN(rstN), .setPtr(setPtr), .addrMode(addrMode),
    .opAddr(opAddr), .wordSel(wordSel), .wrEn(wrEn),
    .wrData(wrData), .rdData(rdData)
  );

  function automatic logic [7:0] fill(input int a);
    return 8'((a * 37) ^ (a >> 5) ^ 8'h5A);
  endfunction

  task automatic check(input string req, input logic [15:0] got, input logic [15:0] exp);
    nChecks++;
    if (got !== exp) begin
      nFails++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic wr(input logic [1:0] m, input logic [11:0] a, input logic w,
                    input logic [15:0] d, input logic sp);
    @(negedge clk);
    addrMode = m; opAddr = a; wordSel = w; wrData = d; wrEn = 1'b1; setPtr = sp;
    @(posedge clk);
    @(negedge clk);
    wrEn = 1'b0; setPtr = 1'b0;
  endtask

  task automatic loadPtr(input logic [7:0] p);
    @(negedge clk);
    wrData = {8'h00, p}; setPtr = 1'b1;
    @(posedge clk);
    @(negedge clk);
    setPtr = 1'b0;
  endtask

  task automatic rd(input logic [1:0] m, input logic [11:0] a, input logic w,
                    output logic [15:0] d);
    addrMode = m; opAddr = a; wordSel = w;
    #0.5;
    d = rdData;
  endtask

  initial begin
    logic [15:0] r;
    repeat (3) @(negedge clk);
    rstN = 1'b1;

    for (int a = 0; a < 4096; a++) wr(2'b10, 12'(a), 1'b0, {8'hEE, fill(a)}, 1'b0);

    for (int a = 0; a < 4096; a++) begin
      rd(2'b10, 12'(a), 1'b0, r);
      check("R6/R5 full byte", r, {8'h00, fill(a)});
    end

    for (int n = 0; n < 16; n++) begin
      rd(2'b00, 12'(n), 1'b0, r);
      check("R1 reset pointer", r, {8'h00, fill(n)});
    end

    for (int p = 0; p < 256; p++) begin
      loadPtr(8'(p));
      for (int n = 0; n < 16; n++) begin
        rd(2'b00, 12'({p[7:0] , 4'(n)}) ^ 12'hAB0, 1'b0, r);
        check("R2/R3 working", r,
              {8'h00, fill(((p & 15) << 8) | ((p >> 4) << 4) | n)});
      end
    end

    for (int pg = 0; pg < 16; pg += 5) begin
      loadPtr(8'(pg | 8'hC0));
      for (int o = 0; o < 256; o++) begin
        rd(2'b01, 12'(o) | 12'hF00, 1'b0, r);
        check("R4 page", r, {8'h00, fill((pg << 8) | o)});
      end
    end

    loadPtr(8'h73);
    wr(2'b00, 12'h006, 1'b0, 16'h00A5, 1'b0);
    rd(2'b10, 12'h376, 1'b0, r);
    check("R3 0x73 reg6 -> 0x376", r, 16'h00A5);
    rd(2'b11, 12'h376, 1'b0, r);
    check("R5 full ignores ptr", r, 16'h00A5);

    for (int a = 0; a < 4096; a += 97) begin
      rd(2'b10, 12'(a), 1'b1, r);
      check("R7 pair read", r,
            {(a == 12'h376 || a == 12'h377) ? 8'h37 ^ 8'h37 ^ fill(a & ~1) : fill(a & ~1),
             fill(a | 1)} ^ (((a & ~1) == 12'h376) ? {fill(12'h376) ^ 8'hA5, 8'h00} : 16'h0));
    end

    wr(2'b10, 12'h201, 1'b1, 16'hBEEF, 1'b0);
    rd(2'b10, 12'h200, 1'b0, r); check("R8 even high byte", r, 16'h00BE);
    rd(2'b10, 12'h201, 1'b0, r); check("R8 odd low byte", r, 16'h00EF);
    rd(2'b10, 12'h1FF, 1'b0, r); check("R8 neighbour below", r, {8'h00, fill(12'h1FF)});
    rd(2'b10, 12'h202, 1'b0, r); check("R8 neighbour above", r, {8'h00, fill(12'h202)});
    rd(2'b10, 12'h201, 1'b1, r); check("R7 odd pair read", r, 16'hBEEF);

    wr(2'b10, 12'h401, 1'b0, 16'h7733, 1'b0);
    rd(2'b10, 12'h401, 1'b0, r); check("R9 byte written", r, 16'h0033);
    rd(2'b10, 12'h400, 1'b0, r); check("R9 partner kept", r, {8'h00, fill(12'h400)});

    wr(2'b10, 12'h555, 1'b0, 16'h0042, 1'b1);
    rd(2'b10, 12'h555, 1'b0, r); check("R10 write suppressed", r, {8'h00, fill(12'h555)});
    rd(2'b00, 12'h009, 1'b0, r); check("R10 pointer loaded", r, {8'h00, fill(12'h249)});

    done = 1'b1;
    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      nChecks++;
      nFails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
      $finish;
    end
  end
endmodule